// File: doc/BRIEF.md
# Three-wire converter read controller

This block is the host side of a three-wire link to a 16-bit sampling converter. It owns the active-low select line and the serial clock, and it listens on the converter's single data line. A start request begins a cycle. The controller first learns that the converter has finished converting. It can do this by waiting a fixed cycle count with select high. It can also drop select with the clock parked high and wait for the data line to read low. It then clocks the word in with the most significant bit first and reports it as a one-cycle valid pulse with a held data word.

When the last bit is in, the controller starts the converter's next conversion in one of two ways. It can simply raise select. It can instead give one more high-to-low clock transition while select is still low, and then release select. The serial rate comes from a divider value: every clock phase lasts that value plus one system cycle. An abort input ends any cycle at once. The partial word is then thrown away.

Top module: `adc3w_reader`

## Requirements
- R1: During reset and in the first cycle after it, `cs_n_o` is 1, `busy_o` is 0, `valid_o` is 0 and `data_o` is 0.
- R2: While select is low, consecutive serial clock edges are exactly `div_i`+1 system cycles apart.
- R3: A completed read holds `cs_n_o` low across exactly 16 rising clock edges. `sdo_i` is sampled at each rise, and the first bit sampled becomes `data_o[15]`. Select is high whenever `busy_o` is 0.
- R4: In timer mode, `cs_n_o` stays high for at least `CONV_CYCLES` cycles after the start request before it falls.
- R5: Polling (`cfg_poll_i`=1 with `cfg_idle_high_i`=1): in the cycle after the start request, `cs_n_o` is 0 and `sck_o` is 1. No falling clock edge occurs while `sdo_i` reads high.
- R6: With `cfg_idle_high_i`=0, timer mode is used whatever `cfg_poll_i` says, so select stays high after the start request.
- R7: With `cfg_rearm_clk_i`=0, no falling clock edge follows the 16th rise while select is low. Select rises to end the read.
- R8: With `cfg_rearm_clk_i`=1, exactly one falling clock edge follows the 16th rise while select is low, and select then rises.
- R9: `valid_o` is high for one cycle per completed read. `data_o` changes only in that cycle and otherwise holds the last word.
- R10: `busy_o` rises in the cycle after an accepted start and falls with `valid_o` or after an abort. Start requests while busy have no effect.
- R11: `abort_i` while busy makes `cs_n_o` 1 and `busy_o` 0 in the next cycle. No `valid_o` follows for that read, and `data_o` is unchanged.
- R12: While idle, `sck_o` equals the configured idle level `cfg_idle_high_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| start_i | input | 1 | Request one conversion-read cycle |
| abort_i | input | 1 | End the current cycle and raise select |
| cfg_poll_i | input | 1 | 1: find completion by polling the data line |
| cfg_idle_high_i | input | 1 | Serial clock idle level |
| cfg_rearm_clk_i | input | 1 | 1: start the next conversion with an extra clock fall |
| div_i | input | DIV_W | Clock phase length minus one, in system cycles |
| sdo_i | input | 1 | Converter data / status line |
| cs_n_o | output | 1 | Active-low select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Cycle in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | DATA_W | Last completed word |

## Verification
On every cycle the assertions check the one-cycle valid pulse, the hold of the result word, the immediate response to an abort, select staying high while idle, the clock idle level, and which entry path each start takes for the idle-level and polling settings. The bench has to show what only a full cycle against a converter model reveals. That covers the word assembled most significant bit first, the count of rising edges, the phase length for each divider value, the minimum wait in timer mode, the absence of clocking while the converter reports busy, and the single extra fall (or its absence) for each re-arm method. These are swept over every combination of idle level, completion method, re-arm method and two divider values.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_POLL,
        ST_LOW,
        ST_HIGH,
        ST_EXTRA
    } rd_state_e;
endpackage

// File: rtl/adc3w_tick.sv
// Phase timer: tick_o every div_i+1 cycles, restarted by clr_i.
module adc3w_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !clr_i && (cnt_q == div_i);
        cnt_d  = (clr_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc3w_timer.sv
// Conversion wait: done_o after LIMIT consecutive enabled cycles.
module adc3w_timer #(
    parameter int LIMIT = 2_100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic done_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = en_i && (cnt_q == LAST);
        cnt_d  = (!en_i || done_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc3w_shift.sv
// Serial-in word register, newest bit enters at bit 0.
module adc3w_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign word_d[i] = shift_i ? bit_i : word_q[i];
        end else begin : g_up
            assign word_d[i] = shift_i ? word_q[i-1] : word_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/adc3w_reader.sv
module adc3w_reader
    import adc3w_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 8,
    parameter int CONV_CYCLES = 2_100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              cfg_poll_i,
    input  logic              cfg_idle_high_i,
    input  logic              cfg_rearm_clk_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    typedef struct packed {
        rd_state_e         st;
        logic              cs_n;
        logic              sck;
        logic [CNT_W-1:0]  bits;
        logic              valid;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t q, d;
    logic tick, tick_clr, tmr_en, tmr_done, smp, poll_ok;
    logic [DATA_W-1:0] word;

    // Polling needs the clock parked high; otherwise the timer decides.
    assign poll_ok = cfg_poll_i & cfg_idle_high_i;

    adc3w_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(tick_clr), .div_i(div_i), .tick_o(tick)
    );

    adc3w_timer #(.LIMIT(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .en_i(tmr_en), .done_o(tmr_done)
    );

    adc3w_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(smp), .bit_i(sdo_i), .word_o(word)
    );

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        tick_clr = 1'b0;
        tmr_en   = 1'b0;
        smp      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                tick_clr = 1'b1;
                d.cs_n   = 1'b1;
                d.sck    = cfg_idle_high_i;
                if (start_i) begin
                    d.bits = '0;
                    if (poll_ok) begin
                        d.st   = ST_POLL;
                        d.cs_n = 1'b0;
                        d.sck  = 1'b1;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                tick_clr = 1'b1;
                tmr_en   = 1'b1;
                if (tmr_done) begin
                    d.st   = ST_SETUP;
                    d.cs_n = 1'b0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    d.st  = ST_LOW;
                    d.sck = 1'b0;
                end
            end
            ST_POLL: begin
                tick_clr = 1'b1;
                if (!sdo_i) begin
                    d.st  = ST_LOW;
                    d.sck = 1'b0;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.st   = ST_HIGH;
                    d.sck  = 1'b1;
                    d.bits = q.bits + 1'b1;
                    smp    = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.bits == LAST_BIT) begin
                        if (cfg_rearm_clk_i) begin
                            d.st  = ST_EXTRA;
                            d.sck = 1'b0;
                        end else begin
                            d.st    = ST_IDLE;
                            d.cs_n  = 1'b1;
                            d.sck   = cfg_idle_high_i;
                            d.valid = 1'b1;
                            d.data  = word;
                        end
                    end else begin
                        d.st  = ST_LOW;
                        d.sck = 1'b0;
                    end
                end
            end
            ST_EXTRA: begin
                if (tick) begin
                    d.st    = ST_IDLE;
                    d.cs_n  = 1'b1;
                    d.sck   = cfg_idle_high_i;
                    d.valid = 1'b1;
                    d.data  = word;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (abort_i && q.st != ST_IDLE) begin
            d.st    = ST_IDLE;
            d.cs_n  = 1'b1;
            d.sck   = cfg_idle_high_i;
            d.valid = 1'b0;
            d.data  = q.data;
            smp     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.sck   <= 1'b1;
            q.bits  <= '0;
            q.valid <= 1'b0;
            q.data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o  = q.cs_n;
    assign sck_o   = q.sck;
    assign busy_o  = (q.st != ST_IDLE);
    assign valid_o = q.valid;
    assign data_o  = q.data;
endmodule

// File: rtl/adc3w_reader_chk.sv
module adc3w_reader_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic              cfg_poll_i,
    input logic              cfg_idle_high_i,
    input logic              cs_n_o,
    input logic              sck_o,
    input logic              busy_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o
);
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> (!busy_o && cs_n_o && !valid_o));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !abort_i) |=> (busy_o || valid_o));

    assert_valid_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

    assert_select_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    assert_timer_when_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && !$past(cfg_idle_high_i)) |-> cs_n_o);

    assert_poll_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && $past(cfg_poll_i) && $past(cfg_idle_high_i)) |-> (!cs_n_o && sck_o));

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy_o && !$past(busy_o)) |-> (sck_o == $past(cfg_idle_high_i)));
endmodule

bind adc3w_reader adc3w_reader_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .cfg_poll_i(cfg_poll_i), .cfg_idle_high_i(cfg_idle_high_i),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .busy_o(busy_o), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/sim_adc3w_reader.sv
module sim_adc3w_reader;
    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 40;   // controller wait, cycles
    localparam int CT         = 30;   // model conversion time, cycles
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0;
    logic cfg_poll = 1'b0, cfg_ih = 1'b1, cfg_rc = 1'b0;
    logic [7:0] div = 8'd0;
    logic sdo = 1'b1;
    logic cs_n, sck, busy, valid;
    logic [15:0] data;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc3w_reader #(.DATA_W(16), .DIV_W(8), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .cfg_poll_i(cfg_poll), .cfg_idle_high_i(cfg_ih), .cfg_rearm_clk_i(cfg_rc),
        .div_i(div), .sdo_i(sdo), .cs_n_o(cs_n), .sck_o(sck), .busy_o(busy),
        .valid_o(valid), .data_o(data)
    );

    // Converter model, updated away from the active edge.
    int req_id = 0;
    logic [15:0] req_word = 16'h0;
    int m_seen = 0, m_conv = 0, m_idx = 15, m_rises = 0, m_xfalls = 0;
    int m_csfall = 0, m_last = -1, m_imin = 1000000, m_imax = 0, m_badfall = 0, m_valids = 0;
    bit m_rose = 0, m_trig = 0;
    logic m_cs_p = 1'b1, m_sck_p = 1'b1;
    logic [15:0] m_word = 16'h0, m_vdata = 16'h0;

    always @(negedge clk) begin
        if (req_id != m_seen) begin
            m_seen = req_id; m_word = req_word; m_conv = CT;
            m_imin = 1000000; m_imax = 0; m_last = -1; m_badfall = 0;
            m_rises = 0; m_xfalls = 0; m_trig = 0;
        end else if (m_conv > 0) begin
            m_conv = m_conv - 1;
        end
        if (valid) begin m_valids = m_valids + 1; m_vdata = data; end
        if (m_cs_p && !cs_n) begin
            m_idx = 15; m_rose = 0; m_rises = 0; m_xfalls = 0;
            m_csfall = cyc; m_last = -1; m_trig = 0;
        end else if (!m_cs_p && !cs_n && sck != m_sck_p) begin
            if (m_last >= 0) begin
                if (cyc - m_last < m_imin) m_imin = cyc - m_last;
                if (cyc - m_last > m_imax) m_imax = cyc - m_last;
            end
            m_last = cyc;
            if (sck) begin
                m_rose = 1; m_rises = m_rises + 1;
            end else begin
                if (m_conv > 0) m_badfall = m_badfall + 1;
                if (m_rises >= 16) begin
                    m_xfalls = m_xfalls + 1;
                    if (!m_trig) begin m_trig = 1; m_conv = CT; end
                end else if (m_rose) begin
                    m_idx = m_idx - 1;
                end
            end
        end
        if (!m_cs_p && cs_n && !m_trig) begin m_trig = 1; m_conv = CT; end
        m_cs_p = cs_n; m_sck_p = sck;
        sdo = cs_n ? 1'b1 : ((m_conv > 0) ? 1'b1 : m_word[m_idx]);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_read(input bit ih, input bit pl, input bit rc, input int dv,
                           input logic [15:0] w, input int abort_at, input bit extra_start);
        int vbefore, t, t0;
        logic [15:0] dprev;
        bit pe, aborted;
        pe = pl & ih;
        @(negedge clk);
        cfg_ih = ih; cfg_poll = pl; cfg_rc = rc; div = 8'(dv);
        repeat (3) @(negedge clk);
        chk(sck == ih, "R12 idle clock level", sck, ih);
        chk(cs_n == 1'b1 && busy == 1'b0, "R10 idle before start", {cs_n, busy}, 2);
        req_word = w; req_id++;
        @(negedge clk);
        vbefore = m_valids; dprev = data;
        start = 1'b1; t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        if (pe)            chk(cs_n == 1'b0 && sck == 1'b1, "R5 poll entry", {cs_n, sck}, 1);
        else if (pl && !ih) chk(cs_n == 1'b1, "R6 timer forced", cs_n, 1);
        else               chk(cs_n == 1'b1, "R4 select high while waiting", cs_n, 1);
        t = 0; aborted = 0;
        while (busy && t < 5000) begin
            @(negedge clk); t++;
            start = (extra_start && m_rises == 4) ? 1'b1 : 1'b0;
            if (abort_at >= 0 && !aborted && m_rises == abort_at) begin
                abort = 1'b1;
                @(negedge clk);
                abort = 1'b0; aborted = 1;
                chk(busy == 1'b0 && cs_n == 1'b1, "R11 abort releases select", {busy, cs_n}, 1);
            end
        end
        start = 1'b0;
        chk(t < 5000, "R10 cycle completes", t, 0);
        repeat (4) @(negedge clk);
        if (aborted) begin
            chk(m_valids == vbefore, "R11 no valid after abort", m_valids, vbefore);
            chk(data == dprev, "R11 data unchanged", data, dprev);
        end else begin
            chk(m_valids == vbefore + 1, "R9 one valid pulse", m_valids, vbefore + 1);
            chk(m_vdata == w, "R3 word msb first", m_vdata, w);
            chk(data == w, "R9 data held", data, w);
            chk(m_rises == 16, "R3 rising edges", m_rises, 16);
            if (rc) chk(m_xfalls == 1, "R8 one extra fall", m_xfalls, 1);
            else    chk(m_xfalls == 0, "R7 no extra fall", m_xfalls, 0);
            chk(m_imin == dv + 1 && m_imax == dv + 1, "R2 phase length", m_imax, dv + 1);
            if (pe) chk(m_badfall == 0, "R5 no clocking while busy", m_badfall, 0);
            else    chk(m_csfall - t0 >= CONV, "R4 conversion wait", m_csfall - t0, CONV);
            chk(busy == 1'b0, "R10 extra start ignored", busy, 0);
        end
    endtask

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        logic [15:0] w;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0 && valid == 1'b0 && data == 16'h0,
            "R1 reset state", {cs_n, busy, valid}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0 && valid == 1'b0 && data == 16'h0,
            "R1 after reset", {cs_n, busy, valid}, 4);
        k = 0;
        for (int ih = 0; ih < 2; ih++)
            for (int pl = 0; pl < 2; pl++)
                for (int rc = 0; rc < 2; rc++)
                    for (int dvi = 0; dvi < 2; dvi++) begin
                        w = 16'((k + 3) * 16'h1357) ^ 16'(k << 9);
                        if (pl == 1 && ih == 1) w[15] = 1'b0;
                        do_read(ih[0], pl[0], rc[0], dvi * 3, w, -1, k == 5);
                        k++;
                    end
        do_read(1'b1, 1'b0, 1'b0, 1, 16'hA5C3, 7, 1'b0);
        do_read(1'b1, 1'b0, 1'b1, 0, 16'h5AA5, -1, 1'b0);
        do_read(1'b1, 1'b1, 1'b0, 0, 16'h1234, 0, 1'b0);
        do_read(1'b0, 1'b0, 1'b1, 2, 16'hFFFF, -1, 1'b0);
        do_read(1'b1, 1'b1, 1'b1, 1, 16'h0001, -1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule